// File: doc/BRIEF.md
# Attention-Framed Open-Drain Byte Transmitter

This block empties a byte queue onto a two-line open-drain bus made of a data line and an attention line. When the queue holds data, the block claims the bus by pulling the attention line low. It waits a lead-in interval and then sends each queued byte as a framed character: a low start bit, the data bits with the least significant bit first, and a released stop bit. The attention line stays low between characters for as long as bytes remain queued. It is released only once the queue has drained.

Every interval is measured with a one-cycle tick enable that pulses four times per bit period. Both outputs are drive enables. A 1 enables the low driver and pulls the line to 0. A 0 releases the line, and the external pull-up then takes it to 1. The queue is a show-ahead FIFO outside this block. Its head word is visible on the read data input, and the block consumes that word with a single-cycle pop strobe.

Top module: `attn_serial_tx`

## Requirements
- R1: After reset both drive enables are 0, busy is 0 and the pop strobe is 0.
- R2: While the FIFO reports empty and the block is idle, both drive enables remain 0.
- R3: In idle, a tick edge that sees the FIFO not empty sets the attention drive enable to 1. The data drive enable stays 0 for 2 bit times (8 ticks). On the 8th tick it goes to 1, which is the start bit.
- R4: The start bit lasts 4 ticks. On the tick that ends it, the pop strobe is 1 for exactly that one clock cycle, and the popped byte's bit 0 is put on the line.
- R5: Each of the 8 data bits lasts 4 ticks and is sent in order from bit 0 to bit 7. A bit value of 0 appears as data drive enable 1, and a bit value of 1 appears as data drive enable 0.
- R6: After bit 7, the data drive enable is 0 for one bit time (4 ticks); this is the stop bit.
- R7: If the FIFO is not empty when the stop bit ends, the attention drive enable stays 1. The data line stays released for a further 4 ticks before the next start bit.
- R8: If the FIFO is empty when the stop bit ends, the attention drive enable returns to 0 on that tick edge and the block returns to idle.
- R9: Busy is 1 exactly while the attention drive enable is 1.
- R10: The drive enables and busy change only on clock edges where tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing enable, four pulses per bit period |
| fifo_empty | input | 1 | Transmit FIFO holds no bytes |
| fifo_rdata | input | DATA_BITS | Head word of the show-ahead FIFO |
| fifo_pop | output | 1 | Consume the head word (one cycle) |
| data_drive | output | 1 | 1 pulls the data line low |
| attn_drive | output | 1 | 1 pulls the attention line low |
| busy | output | 1 | Message in progress |

## Verification
The hardest case to reach is a byte that joins a message already in progress. The byte must be queued after the previous pop but before that character's stop bit ends. Only then does the block take the short inter-byte gap and keep the attention line low, rather than releasing the bus. The stimulus pushes one byte, waits until its data bits are on the line, and then pushes a second byte. A later burst queues three bytes at once so that the gap path is also taken twice in a row. A bus-level monitor counts ticks from each attention edge, decodes each character and compares it with the queue of expected bytes.

// File: rtl/attn_serial_tx.sv
module attn_serial_tx #(
  parameter int TICKS_PER_BIT = 4,
  parameter int LEAD_BITS     = 2,
  parameter int GAP_BITS      = 1,
  parameter int DATA_BITS     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 fifo_empty,
  input  logic [DATA_BITS-1:0] fifo_rdata,
  output logic                 fifo_pop,
  output logic                 data_drive,
  output logic                 attn_drive,
  output logic                 busy
);
  localparam int LEAD_T = LEAD_BITS * TICKS_PER_BIT;
  localparam int GAP_T  = GAP_BITS * TICKS_PER_BIT;
  localparam int MAX_T  = (LEAD_T > GAP_T) ? ((LEAD_T > TICKS_PER_BIT) ? LEAD_T : TICKS_PER_BIT)
                                           : ((GAP_T > TICKS_PER_BIT) ? GAP_T : TICKS_PER_BIT);
  localparam int CW     = $clog2(MAX_T + 1);
  localparam int BW     = $clog2(DATA_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_START, S_BITS, S_STOP} st_t;

  st_t                  state;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bits_left;
  logic [DATA_BITS-1:0] shreg;
  logic                 expired;

  assign expired  = tick && (cnt <= CW'(1));
  assign fifo_pop = expired && (state == S_START);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      bits_left  <= '0;
      shreg      <= '0;
      data_drive <= 1'b0;
      attn_drive <= 1'b0;
    end else if (tick) begin
      cnt <= (cnt == '0) ? '0 : cnt - CW'(1);
      case (state)
        S_IDLE: if (!fifo_empty) begin
          attn_drive <= 1'b1;
          cnt        <= CW'(LEAD_T);
          state      <= S_LEAD;
        end
        S_LEAD: if (expired) begin
          data_drive <= 1'b1;
          cnt        <= CW'(TICKS_PER_BIT);
          state      <= S_START;
        end
        S_START: if (expired) begin
          data_drive <= ~fifo_rdata[0];
          shreg      <= fifo_rdata >> 1;
          bits_left  <= BW'(DATA_BITS);
          cnt        <= CW'(TICKS_PER_BIT);
          state      <= S_BITS;
        end
        S_BITS: if (expired) begin
          cnt <= CW'(TICKS_PER_BIT);
          if (bits_left == BW'(1)) begin
            data_drive <= 1'b0;
            state      <= S_STOP;
          end else begin
            data_drive <= ~shreg[0];
            shreg      <= shreg >> 1;
            bits_left  <= bits_left - BW'(1);
          end
        end
        S_STOP: if (expired) begin
          if (!fifo_empty) begin
            cnt   <= CW'(GAP_T);
            state <= S_LEAD;
          end else begin
            attn_drive <= 1'b0;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_reset_released: assert property (@(posedge clk)
    $past(!rst_n) |-> (!data_drive && !attn_drive && !busy));

  a_r4_pop_only_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (!fifo_empty && tick));

  a_r3_data_quiet_at_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attn_drive) |-> !data_drive);

  a_r5_data_only_under_attn: assert property (@(posedge clk) disable iff (!rst_n)
    data_drive |-> attn_drive);

  a_r8_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attn_drive) |-> !data_drive);

  a_r9_busy_tracks_attn: assert property (@(posedge clk) disable iff (!rst_n)
    busy == attn_drive);

  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable({data_drive, attn_drive, busy}));
endmodule

// File: tb/tb_attn_serial_tx.sv
module tb_attn_serial_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic fifo_empty = 1'b1;
  logic [7:0] fifo_rdata = '0;
  logic fifo_pop, data_drive, attn_drive, busy;

  int checks = 0;
  int fails = 0;
  bit mon_on = 0;
  int divc = 0;
  logic [7:0] fifo_q[$];
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  attn_serial_tx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .data_drive(data_drive),
    .attn_drive(attn_drive), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    divc <= (divc == 2) ? 0 : divc + 1;
    tick <= (divc == 2);
    fifo_empty <= (fifo_q.size() == 0);
    fifo_rdata <= (fifo_q.size() != 0) ? fifo_q[0] : 8'h00;
  end

  always @(posedge clk)
    if (fifo_pop && fifo_q.size() != 0) void'(fifo_q.pop_front());

  task automatic send_byte(input logic [7:0] b);
    fifo_q.push_back(b);
    exp_q.push_back(b);
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk); #1;
      if (tick) k++;
    end
  endtask

  logic pd = 0, pa = 0, pb = 0;
  always @(posedge clk) begin
    #1;
    if (mon_on && rst_n) begin
      check("R9 busy vs attn", busy, attn_drive);
      if (!tick) check("R10 stable without tick", {data_drive, attn_drive, busy}, {pd, pa, pb});
    end
    pd = data_drive; pa = attn_drive; pb = busy;
  end

  initial begin
    logic [7:0] got;
    logic [7:0] want;
    bit more;
    wait (mon_on);
    forever begin
      @(posedge clk); #1;
      if (attn_drive) begin
        wait_ticks(7);
        check("R3 lead-in data released", data_drive, 1'b0);
        wait_ticks(1);
        check("R3 start bit after lead-in", data_drive, 1'b1);
        more = 1;
        while (more) begin
          for (int i = 0; i < 8; i++) begin
            wait_ticks(4);
            got[i] = ~data_drive;
          end
          wait_ticks(4);
          check("R6 stop bit released", data_drive, 1'b0);
          check("R6 attn held in stop", attn_drive, 1'b1);
          want = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hxx;
          check("R5 byte lsb first", got, want);
          wait_ticks(4);
          if (attn_drive) begin
            check("R7 queued byte pending", exp_q.size() != 0, 1'b1);
            wait_ticks(3);
            check("R7 gap data released", data_drive, 1'b0);
            check("R7 attn held in gap", attn_drive, 1'b1);
            wait_ticks(1);
            check("R7 next start bit", data_drive, 1'b1);
          end else begin
            check("R8 drained on release", exp_q.size(), 0);
            check("R8 busy low", busy, 1'b0);
            more = 0;
          end
        end
      end
    end
  end

  int pops = 0;
  always @(posedge clk) if (rst_n && fifo_pop) begin
    pops++;
    check("R4 pop coincides with tick", tick, 1'b1);
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic wait_idle();
    while (exp_q.size() != 0 || busy) @(posedge clk);
    repeat (30) @(posedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    check("R1 data released", data_drive, 1'b0);
    check("R1 attn released", attn_drive, 1'b0);
    check("R1 busy low", busy, 1'b0);
    check("R1 no pop", fifo_pop, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    mon_on = 1;
    repeat (60) @(posedge clk);
    #1;
    check("R2 idle data released", data_drive, 1'b0);
    check("R2 idle attn released", attn_drive, 1'b0);

    @(negedge clk) send_byte(8'hA5);
    wait_idle();
    check("R4 one pop per byte", pops, 1);

    @(negedge clk) send_byte(8'h01);
    wait (data_drive == 1'b1);
    repeat (40) @(posedge clk);
    @(negedge clk) send_byte(8'h80);
    wait_idle();
    check("R4 pops after join", pops, 3);

    @(negedge clk) begin
      send_byte(8'h00);
      send_byte(8'hFF);
      send_byte(8'h3C);
    end
    wait_idle();
    check("R4 pops after burst", pops, 6);
    check("R8 final attn released", attn_drive, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule